// File: doc/BRIEF.md
# Configurable GPIO interrupt detector

This block turns the pins of a small input/output port into interrupt requests. Each line is set up on its own. It can watch a level, either high or low. It can instead watch an edge: rising, falling, or both. Every pin passes through a synchroniser first. Edges are found by comparing the synchronised value with its value one clock earlier.

A line set to edge sensing keeps its status bit until software writes a one to that bit through the clear address. A line set to level sensing shows the live state of the pin, so its status drops by itself once the pin leaves the active level. A per-line enable mask selects which status bits reach the masked status and the single combined interrupt output. That output is registered.

Configuration is written through a narrow write port: an address, a data byte and a write strobe. The bus bridge and the data and direction path sit outside this block.

Top module: `gpio_irq_detector`

## Requirements
- R1: After reset, every configuration register is zero, including all enable bits. The raw status, the masked status and `irq` are zero. While the enables stay zero, no active pin raises `irq` or any masked status bit.
- R2: With level-select bit n at 1, line n is level sensed. Its raw status is 1 while the synchronised pin equals the polarity bit (polarity 1 means high is active, 0 means low is active) and 0 otherwise, with no latching.
- R3: With level-select bit n at 0 and dual-edge bit n at 0, line n sets its raw status on a rising edge when polarity bit n is 1, or on a falling edge when it is 0. The opposite edge sets nothing.
- R4: With dual-edge bit n at 1 on an edge-sensed line, both rising and falling edges set raw status bit n, whatever the polarity bit holds.
- R5: On an edge-sensed line, a set raw status bit stays set until it is cleared, even after the pin returns to its earlier level.
- R6: A write to the clear address with data bit n at 1 clears the latched status of edge line n at the clock edge that takes the write. Data bits at 0 leave their lines unchanged, and level-sensed lines ignore clear writes.
- R7: If an edge is detected on a line in the same cycle that a clear write for that line takes effect, the raw status bit stays set.
- R8: Masked status equals raw status ANDed with the enable register. A line whose enable bit is 0 never appears in the masked status.
- R9: `irq` is a register. Its value is the OR of all masked status bits one clock earlier.
- R10: A pin change takes effect as follows. At the second rising clock edge after the change, raw status is still unchanged. At the third edge, raw status shows the change. At the fourth edge, `irq` shows it.
- R11: Write addresses on `cfg_addr` are: 0 level-select, 1 dual-edge, 2 polarity, 3 enable, 4 clear. A write replaces only the addressed register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_in | input | LINES | Port pins, asynchronous to clk |
| cfg_we | input | 1 | Write strobe for the configuration port |
| cfg_addr | input | 3 | Register address (encoding in R11) |
| cfg_wdata | input | LINES | Write data, one bit per line |
| raw_status | output | LINES | Status before masking |
| masked_status | output | LINES | Status ANDed with the enable mask |
| irq | output | 1 | Registered OR of the masked status |

## Verification
A table drives eight configurations, each with a pin pattern before and after a change. The patterns cover:
- rising only and falling only, which show that the polarity bit picks the edge;
- both edges with the polarity bit at 0, which shows that the dual-edge bit overrides polarity;
- high-level and low-level sensing on a mixed pattern, which shows the level polarity;
- a mixed per-line setup with a partial mask, which separates raw status from masked status;
- an all-disabled mask, which shows the mask blocking the output.

Directed tests then cover the rest:
- the exact latency of raw status and `irq`;
- latching after the pin returns;
- partial and zero clear writes, and clear writes on level lines;
- a clear that lands in the same cycle as a new edge.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    // Write-port addresses for the configuration registers.
    typedef enum logic [2:0] {
        ADDR_LEVEL_SEL = 3'd0,
        ADDR_DUAL_EDGE = 3'd1,
        ADDR_POLARITY  = 3'd2,
        ADDR_ENABLE    = 3'd3,
        ADDR_CLEAR     = 3'd4
    } cfg_addr_e;

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_o,
    output logic [WIDTH-1:0] prev_o
);

    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] chain;
        logic [WIDTH-1:0]             prev;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.chain[0] = async_in;
        for (int i = 1; i < STAGES; i++) begin
            st_d.chain[i] = st_q.chain[i-1];
        end
        st_d.prev = st_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.chain[STAGES-1];
    assign prev_o = st_q.prev;

    // The compare value is the synchronised pin one clock earlier.
    assert_prev_lags_sync_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (prev_o == $past(sync_o)));

endmodule

// File: rtl/gpio_irq_cfg.sv
module gpio_irq_cfg
    import gpio_irq_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  cfg_addr_e        wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] level_sel,
    output logic [WIDTH-1:0] dual_edge,
    output logic [WIDTH-1:0] polarity,
    output logic [WIDTH-1:0] enable,
    output logic [WIDTH-1:0] clr_bits
);

    typedef struct packed {
        logic [WIDTH-1:0] level_sel;
        logic [WIDTH-1:0] dual_edge;
        logic [WIDTH-1:0] polarity;
        logic [WIDTH-1:0] enable;
    } cfg_state_t;

    cfg_state_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            unique case (wr_addr)
                ADDR_LEVEL_SEL: cfg_d.level_sel = wr_data;
                ADDR_DUAL_EDGE: cfg_d.dual_edge = wr_data;
                ADDR_POLARITY:  cfg_d.polarity  = wr_data;
                ADDR_ENABLE:    cfg_d.enable    = wr_data;
                default:        ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign level_sel = cfg_q.level_sel;
    assign dual_edge = cfg_q.dual_edge;
    assign polarity  = cfg_q.polarity;
    assign enable    = cfg_q.enable;
    // Write-one-to-clear pulse, valid only in the cycle of the write.
    assign clr_bits  = (wr_en && wr_addr == ADDR_CLEAR) ? wr_data : '0;

    assert_enable_kept_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != ADDR_ENABLE) |=> $stable(enable));

    assert_level_sel_kept_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en) |=> $stable(level_sel));

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] sync_in,
    input  logic [WIDTH-1:0] prev_in,
    input  logic [WIDTH-1:0] level_sel,
    input  logic [WIDTH-1:0] dual_edge,
    input  logic [WIDTH-1:0] polarity,
    output logic [WIDTH-1:0] edge_hit,
    output logic [WIDTH-1:0] level_on
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_line
        logic rise;
        logic fall;
        logic picked;
        assign rise        = sync_in[i] & ~prev_in[i];
        assign fall        = ~sync_in[i] & prev_in[i];
        // Dual-edge overrides polarity; otherwise polarity picks the edge.
        assign picked      = dual_edge[i] ? (rise | fall)
                                          : (polarity[i] ? rise : fall);
        assign edge_hit[i] = ~level_sel[i] & picked;
        assign level_on[i] = ~(sync_in[i] ^ polarity[i]);
    end

endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level_sel,
    input  logic [WIDTH-1:0] edge_hit,
    input  logic [WIDTH-1:0] level_on,
    input  logic [WIDTH-1:0] clr_bits,
    input  logic [WIDTH-1:0] enable,
    output logic [WIDTH-1:0] raw_o,
    output logic [WIDTH-1:0] masked_o,
    output logic             irq_o
);

    typedef struct packed {
        logic [WIDTH-1:0] raw;
        logic             irq;
    } stat_state_t;

    stat_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // Level lines follow the pin; edge lines hold until cleared, new edge wins.
        st_d.raw = (level_sel & level_on)
                 | (~level_sel & ((st_q.raw & ~clr_bits) | edge_hit));
        st_d.irq = |(st_q.raw & enable);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign raw_o    = st_q.raw;
    assign masked_o = st_q.raw & enable;
    assign irq_o    = st_q.irq;

    assert_level_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((raw_o ^ $past(level_on)) & $past(level_sel)) == '0));

    assert_edge_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(raw_o & ~level_sel & ~clr_bits) & ~raw_o) == '0));

    assert_clear_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(clr_bits & ~level_sel & ~edge_hit) & raw_o) == '0));

    assert_edge_beats_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(edge_hit & clr_bits) & ~raw_o) == '0));

    assert_irq_follows_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == $past(|masked_o)));

    assert_no_irq_disabled_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (enable == '0) |=> !irq_o);

endmodule

// File: rtl/gpio_irq_detector.sv
module gpio_irq_detector
    import gpio_irq_pkg::*;
#(
    parameter int LINES       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] pin_in,
    input  logic             cfg_we,
    input  logic [2:0]       cfg_addr,
    input  logic [LINES-1:0] cfg_wdata,
    output logic [LINES-1:0] raw_status,
    output logic [LINES-1:0] masked_status,
    output logic             irq
);

    logic [LINES-1:0] pin_sync, pin_prev;
    logic [LINES-1:0] level_sel, dual_edge, polarity, enable, clr_bits;
    logic [LINES-1:0] edge_hit, level_on;

    gpio_irq_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_o   (pin_sync),
        .prev_o   (pin_prev)
    );

    gpio_irq_cfg #(.WIDTH(LINES)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_we),
        .wr_addr   (cfg_addr_e'(cfg_addr)),
        .wr_data   (cfg_wdata),
        .level_sel (level_sel),
        .dual_edge (dual_edge),
        .polarity  (polarity),
        .enable    (enable),
        .clr_bits  (clr_bits)
    );

    gpio_irq_detect #(.WIDTH(LINES)) u_detect (
        .sync_in   (pin_sync),
        .prev_in   (pin_prev),
        .level_sel (level_sel),
        .dual_edge (dual_edge),
        .polarity  (polarity),
        .edge_hit  (edge_hit),
        .level_on  (level_on)
    );

    gpio_irq_status #(.WIDTH(LINES)) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .level_sel (level_sel),
        .edge_hit  (edge_hit),
        .level_on  (level_on),
        .clr_bits  (clr_bits),
        .enable    (enable),
        .raw_o     (raw_status),
        .masked_o  (masked_status),
        .irq_o     (irq)
    );

endmodule

// File: tb/gpio_irq_detector_bench.sv
module gpio_irq_detector_bench;

    localparam int LINES = 8;
    localparam logic [2:0] A_LEVEL = 3'd0, A_DUAL = 3'd1, A_POL = 3'd2,
                           A_EN = 3'd3, A_CLR = 3'd4;

    // Fields: level-select, dual-edge, polarity, enable, pins before, pins after, expected raw
    localparam logic [55:0] VEC_TABLE [8] = '{
        56'h00_00_FF_FF_00_0F_0F,
        56'h00_00_00_FF_FF_F0_0F,
        56'h00_FF_00_FF_0F_F0_FF,
        56'hFF_00_FF_FF_00_A5_A5,
        56'hFF_00_00_FF_FF_A5_5A,
        56'hF0_03_CC_3C_00_33_03,
        56'h00_00_FF_00_00_FF_FF,
        56'h00_FF_00_FF_00_55_55
    };
    localparam string VEC_REQ [8] = '{"R3", "R3", "R4", "R2", "R2", "R8", "R8", "R4"};

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [LINES-1:0] pin_in = '0;
    logic             cfg_we = 1'b0;
    logic [2:0]       cfg_addr = '0;
    logic [LINES-1:0] cfg_wdata = '0;
    logic [LINES-1:0] raw_status, masked_status;
    logic             irq;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    gpio_irq_detector #(.LINES(LINES), .SYNC_STAGES(2)) u_gpio_irq_detector (
        .clk           (clk),
        .rst_n         (rst_n),
        .pin_in        (pin_in),
        .cfg_we        (cfg_we),
        .cfg_addr      (cfg_addr),
        .cfg_wdata     (cfg_wdata),
        .raw_status    (raw_status),
        .masked_status (masked_status),
        .irq           (irq)
    );

    task automatic check(input string req, input logic [LINES-1:0] act,
                         input logic [LINES-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Register write through the R11 address map; sampled at the next rising edge.
    task automatic cfg_write(input logic [2:0] addr, input logic [LINES-1:0] data);
        cfg_we = 1'b1; cfg_addr = addr; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0; cfg_wdata = '0;
    endtask

    initial begin
        #(8 * 50000);
        fails++;
        $display("FAIL watchdog: run did not finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        wait_cyc(3);
        // R1: reset state
        check("R1 raw after reset", raw_status, '0);
        check("R1 masked after reset", masked_status, '0);
        check("R1 irq after reset", {7'b0, irq}, '0);
        rst_n = 1'b1;
        wait_cyc(2);

        // R1: enables stay zero, active level pins raise no interrupt
        cfg_write(A_LEVEL, 8'hFF);
        cfg_write(A_POL, 8'hFF);
        pin_in = 8'hFF;
        wait_cyc(5);
        check("R1 raw with enables zero", raw_status, 8'hFF);
        check("R1 masked with enables zero", masked_status, 8'h00);
        check("R1 irq with enables zero", {7'b0, irq}, '0);

        // Table of configurations and pin transitions
        for (int v = 0; v < 8; v++) begin
            logic [55:0] e;
            e = VEC_TABLE[v];
            cfg_write(A_LEVEL, e[55:48]);
            cfg_write(A_DUAL,  e[47:40]);
            cfg_write(A_POL,   e[39:32]);
            cfg_write(A_EN,    e[31:24]);
            pin_in = e[23:16];
            wait_cyc(5);
            cfg_write(A_CLR, 8'hFF);
            wait_cyc(2);
            pin_in = e[15:8];
            wait_cyc(5);
            check(VEC_REQ[v], raw_status, e[7:0]);
            check("R8 masked", masked_status, e[7:0] & e[31:24]);
            check("R9 irq", {7'b0, irq}, {7'b0, |(e[7:0] & e[31:24])});
        end

        // R10 / R9: latency through synchroniser and status register
        cfg_write(A_LEVEL, 8'hFF);
        cfg_write(A_DUAL, 8'h00);
        cfg_write(A_POL, 8'hFF);
        cfg_write(A_EN, 8'hFF);
        pin_in = 8'h00;
        wait_cyc(5);
        check("R10 idle raw", raw_status, 8'h00);
        pin_in = 8'hFF;
        wait_cyc(2);
        check("R10 raw before third edge", raw_status, 8'h00);
        wait_cyc(1);
        check("R10 raw at third edge", raw_status, 8'hFF);
        check("R10 irq not yet", {7'b0, irq}, '0);
        wait_cyc(1);
        check("R9 irq one edge later", {7'b0, irq}, 8'h01);

        // R6: clear ignored on level lines; R2: level status drops with pin
        cfg_write(A_CLR, 8'hFF);
        check("R6 clear ignored on level lines", raw_status, 8'hFF);
        pin_in = 8'h00;
        wait_cyc(3);
        check("R2 level status follows pin", raw_status, 8'h00);

        // R5: edge status latched after the pin returns; R3 falling ignored
        cfg_write(A_LEVEL, 8'h00);
        wait_cyc(4);
        cfg_write(A_CLR, 8'hFF);
        wait_cyc(2);
        pin_in = 8'hFF;
        wait_cyc(4);
        check("R3 rising edges latched", raw_status, 8'hFF);
        pin_in = 8'h00;
        wait_cyc(4);
        check("R5 edge status held after pin returns", raw_status, 8'hFF);

        // R6: partial clear, then zero clear has no effect
        cfg_write(A_CLR, 8'h0F);
        check("R6 partial clear", raw_status, 8'hF0);
        cfg_write(A_CLR, 8'h00);
        wait_cyc(1);
        check("R6 zero clear no effect", raw_status, 8'hF0);

        // R7: edge and clear in the same cycle
        cfg_write(A_CLR, 8'hFF);
        wait_cyc(2);
        check("R6 full clear", raw_status, 8'h00);
        pin_in = 8'h01;
        wait_cyc(2);
        cfg_write(A_CLR, 8'h03);
        check("R7 edge wins over clear", raw_status, 8'h01);
        wait_cyc(2);
        check("R7 bit stays latched", raw_status, 8'h01);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule